// File: doc/BRIEF.md
# Three-Level Space Vector Dwell Sequencer

This block plays out one switching period of a three-level, neutral-clamped inverter from a sector number, a sub-triangle index and three dwell counts. A period-start strobe captures these inputs. On every tick enable the block then advances through a constant switching-state list. The list is picked by sub-triangle and rotated by sector. It is played forward and then backward, so the period is symmetric.

Each phase output carries a three-level code. A small vector's dwell is shared equally between its two redundant states, which draw neutral-point current of opposite sign, so the neutral point gets no net charge over the period. Dwell computation and gate dead-time are done elsewhere.

Top module: `svm_dwell_seq`

## Requirements
- R1: Each phase output uses 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. The code 2'b10 never appears. After reset all three phases are 0 and `active_o` is low.
- R2: Sector, sub-triangle and dwell inputs are captured only in a cycle where `start_i` is high. Changes at any other time have no effect on the running period.
- R3: For sector k, each listed state (a,b,c) is rotated k times by the map (a,b,c) -> (-b,-c,-a). As a result, sectors 6 and 7 behave as sectors 0 and 1.
- R4: Sector 0 lists, written as phase a,b,c:
  - sub-triangle 0: (0,-1,-1)d0p, (0,0,-1)d1p, (0,0,0)d2, (1,0,0)d0p, (1,1,0)d1p
  - sub-triangle 1: (0,-1,-1)d0p, (1,-1,-1)d2, (1,0,-1)d1, (1,0,0)d0p
  - sub-triangle 2: (0,-1,-1)d0p, (0,0,-1)d1p, (1,0,-1)d2, (1,0,0)d0p, (1,1,0)d1p
  - sub-triangle 3: (0,0,-1)d0p, (1,0,-1)d1, (1,1,-1)d2, (1,1,0)d0p
  
  Here dN names the dwell input `dwellN_i` used by the entry, and p marks a redundant-pair entry.
- R5: Each appearance of an entry lasts a number of ticks. For a pair entry this is its dwell shifted right by 2. For any other entry it is its dwell shifted right by 1.
- R6: A period plays the list forward and then in reverse order, so every entry appears twice.
- R7: The first state is output one cycle after the start strobe. `active_o` stays high until the sum of all appearance lengths in ticks has elapsed, and then falls.
- R8: An appearance of length zero is skipped. Its state is never output.
- R9: When no appearance is skipped, consecutive states within a period differ in at most one phase.
- R10: A start strobe restarts the sequence even during a running period. A tick in the start cycle is not counted.
- R11: After a period ends, or after a start in which all appearances are zero, the outputs hold their last value and `active_o` is low. Ticks then have no effect.
- R12: Outputs change only on a cycle with a tick or a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Period-start strobe; captures inputs |
| tick_i | input | 1 | Timer tick enable |
| sector_i | input | 3 | Sector number |
| subtri_i | input | 2 | Sub-triangle index |
| dwell0_i | input | DW | Dwell of first nearest vector |
| dwell1_i | input | DW | Dwell of second nearest vector |
| dwell2_i | input | DW | Dwell of third nearest vector |
| phase_a_o | output | 2 | Phase a level code |
| phase_b_o | output | 2 | Phase b level code |
| phase_c_o | output | 2 | Phase c level code |
| active_o | output | 1 | High while a period is being played |

## Verification
A start strobe and a tick can arrive in the same cycle. A start can also land in the middle of a running period. The bench provokes both by aborting a period after seven ticks with a new start whose tick enable is held high. It judges the outcome by requiring that the new list's first state appears at once and lasts its full length, so the overlapping tick is not counted. Zero-length skips that meet a start are covered separately: a period is started with inputs whose pieces all truncate to zero, and the bench checks that the outputs freeze and `active_o` stays low.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;
  typedef logic [1:0] lvl_t;
  typedef struct packed { lvl_t a; lvl_t b; lvl_t c; } vstate_t;
  typedef struct packed { vstate_t st; logic [1:0] sel; logic pair; } entry_t;

  localparam int unsigned NENT = 5;
  localparam int unsigned NPOS = 2 * NENT;
  localparam lvl_t LP = 2'b01;
  localparam lvl_t LZ = 2'b00;
  localparam lvl_t LN = 2'b11;

  function automatic lvl_t neg_l(lvl_t x);
    return lvl_t'(~x + 2'b01);
  endfunction

  // one 60 degree step
  function automatic vstate_t rot60(vstate_t s);
    vstate_t r;
    r.a = neg_l(s.b);
    r.b = neg_l(s.c);
    r.c = neg_l(s.a);
    return r;
  endfunction

  function automatic entry_t rot_k(entry_t e, logic [2:0] k);
    entry_t r = e;
    for (int i = 0; i < 7; i++)
      if (3'(i) < k) r.st = rot60(r.st);
    return r;
  endfunction

  function automatic entry_t mk(lvl_t a, lvl_t b, lvl_t c, logic [1:0] sel, logic pair);
    entry_t e;
    e.st = '{a: a, b: b, c: c};
    e.sel = sel;
    e.pair = pair;
    return e;
  endfunction

  function automatic logic [2:0] sub_len(logic [1:0] sub);
    return sub[0] ? 3'd4 : 3'd5;
  endfunction

  function automatic entry_t base_entry(logic [1:0] sub, int unsigned i);
    entry_t e = '0;
    case (sub)
      2'd0: case (i)
        0: e = mk(LZ, LN, LN, 2'd0, 1'b1);
        1: e = mk(LZ, LZ, LN, 2'd1, 1'b1);
        2: e = mk(LZ, LZ, LZ, 2'd2, 1'b0);
        3: e = mk(LP, LZ, LZ, 2'd0, 1'b1);
        4: e = mk(LP, LP, LZ, 2'd1, 1'b1);
        default: e = '0;
      endcase
      2'd1: case (i)
        0: e = mk(LZ, LN, LN, 2'd0, 1'b1);
        1: e = mk(LP, LN, LN, 2'd2, 1'b0);
        2: e = mk(LP, LZ, LN, 2'd1, 1'b0);
        3: e = mk(LP, LZ, LZ, 2'd0, 1'b1);
        default: e = '0;
      endcase
      2'd2: case (i)
        0: e = mk(LZ, LN, LN, 2'd0, 1'b1);
        1: e = mk(LZ, LZ, LN, 2'd1, 1'b1);
        2: e = mk(LP, LZ, LN, 2'd2, 1'b0);
        3: e = mk(LP, LZ, LZ, 2'd0, 1'b1);
        4: e = mk(LP, LP, LZ, 2'd1, 1'b1);
        default: e = '0;
      endcase
      default: case (i)
        0: e = mk(LZ, LZ, LN, 2'd0, 1'b1);
        1: e = mk(LP, LZ, LN, 2'd1, 1'b0);
        2: e = mk(LP, LP, LN, 2'd2, 1'b0);
        3: e = mk(LP, LP, LZ, 2'd0, 1'b1);
        default: e = '0;
      endcase
    endcase
    return e;
  endfunction
endpackage

// File: rtl/svm_seq_table.sv
module svm_seq_table
  import svm_seq_pkg::*;
(
  input  logic [2:0]                sector_i,
  input  logic [1:0]                subtri_i,
  output entry_t [NENT-1:0]         ent_o,
  output logic [2:0]                len_o
);
  assign len_o = sub_len(subtri_i);

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    assign ent_o[i] = rot_k(base_entry(subtri_i, i), sector_i);
  end
endmodule

// File: rtl/svm_seg_finder.sv
module svm_seg_finder
  import svm_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  entry_t [NENT-1:0]      ent_i,
  input  logic [2:0]             len_i,
  input  logic [2:0][DW-1:0]     dwell_i,
  input  logic [4:0]             from_i,
  output logic                   found_o,
  output logic [3:0]             pos_o,
  output logic [DW-1:0]          seg_o,
  output vstate_t                st_o
);
  logic [3:0]                len2;
  logic [NPOS-1:0][DW-1:0]   seg_p;
  vstate_t [NPOS-1:0]        st_p;

  assign len2 = {len_i, 1'b0};

  // flattened forward+reverse positions
  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    logic       valid, fwd;
    logic [2:0] idx;
    entry_t     e;
    logic [DW-1:0] d;

    assign valid = 4'(p) < len2;
    assign fwd   = 4'(p) < {1'b0, len_i};
    assign idx   = !valid ? 3'd0 : (fwd ? 3'(p) : 3'(len2 - 4'd1 - 4'(p)));
    assign e     = ent_i[idx];

    always_comb begin
      case (e.sel)
        2'd0:    d = dwell_i[0];
        2'd1:    d = dwell_i[1];
        2'd2:    d = dwell_i[2];
        default: d = '0;
      endcase
    end

    assign seg_p[p] = !valid ? '0 : (e.pair ? (d >> 2) : (d >> 1));
    assign st_p[p]  = e.st;
  end

  // lowest position at or after from_i with a nonzero length
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    seg_o   = '0;
    st_o    = '0;
    for (int p = NPOS - 1; p >= 0; p--) begin
      if (seg_p[p] != '0 && 5'(p) >= from_i) begin
        found_o = 1'b1;
        pos_o   = 4'(p);
        seg_o   = seg_p[p];
        st_o    = st_p[p];
      end
    end
  end
endmodule

// File: rtl/svm_dwell_seq.sv
module svm_dwell_seq
  import svm_seq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [2:0]    sector_i,
  input  logic [1:0]    subtri_i,
  input  logic [DW-1:0] dwell0_i,
  input  logic [DW-1:0] dwell1_i,
  input  logic [DW-1:0] dwell2_i,
  output logic [1:0]    phase_a_o,
  output logic [1:0]    phase_b_o,
  output logic [1:0]    phase_c_o,
  output logic          active_o
);
  logic [2:0]           sec_q, sec_m;
  logic [1:0]           sub_q, sub_m;
  logic [2:0][DW-1:0]   dw_q, dw_m, dw_in;
  logic [3:0]           pos_q;
  logic [DW-1:0]        cnt_q;
  logic                 act_q;
  vstate_t              st_q;

  entry_t [NENT-1:0]    ent;
  logic [2:0]           len;
  logic [4:0]           from;
  logic                 fnd;
  logic [3:0]           fnd_pos;
  logic [DW-1:0]        fnd_seg;
  vstate_t              fnd_st;

  assign dw_in = {dwell2_i, dwell1_i, dwell0_i};
  // start cycle looks at fresh inputs
  assign sec_m = start_i ? sector_i : sec_q;
  assign sub_m = start_i ? subtri_i : sub_q;
  assign dw_m  = start_i ? dw_in    : dw_q;
  assign from  = start_i ? 5'd0 : ({1'b0, pos_q} + 5'd1);

  svm_seq_table u_table (
    .sector_i (sec_m),
    .subtri_i (sub_m),
    .ent_o    (ent),
    .len_o    (len)
  );

  svm_seg_finder #(.DW(DW)) u_finder (
    .ent_i   (ent),
    .len_i   (len),
    .dwell_i (dw_m),
    .from_i  (from),
    .found_o (fnd),
    .pos_o   (fnd_pos),
    .seg_o   (fnd_seg),
    .st_o    (fnd_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
      dw_q  <= '0;
      pos_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      st_q  <= '0;
    end else if (start_i) begin
      sec_q <= sector_i;
      sub_q <= subtri_i;
      dw_q  <= dw_in;
      act_q <= fnd;
      if (fnd) begin
        pos_q <= fnd_pos;
        cnt_q <= fnd_seg;
        st_q  <= fnd_st;
      end
    end else if (act_q && tick_i) begin
      if (cnt_q > 1) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (fnd) begin
        pos_q <= fnd_pos;
        cnt_q <= fnd_seg;
        st_q  <= fnd_st;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  assign phase_a_o = st_q.a;
  assign phase_b_o = st_q.b;
  assign phase_c_o = st_q.c;
  assign active_o  = act_q;

  p_legal_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.a != 2'b10 && st_q.b != 2'b10 && st_q.c != 2'b10);

  p_live_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cnt_q != '0);

  p_hold_no_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !tick_i |=> $stable(st_q));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q && !start_i |=> $stable(st_q) && !act_q);

  p_one_phase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && act_q && tick_i && cnt_q == 1 && fnd && fnd_pos == pos_q + 4'd1
    |=> $countones({st_q.a != $past(st_q.a), st_q.b != $past(st_q.b),
                    st_q.c != $past(st_q.c)}) <= 1);
endmodule

// File: tb/tb_svm_dwell_seq.sv
module tb_svm_dwell_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0;
  logic [2:0] sector = '0;
  logic [1:0] subtri = '0;
  logic [DW-1:0] d0 = '0, d1 = '0, d2 = '0;
  logic [1:0] pa, pb, pc;
  logic active;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [5:0] exp_st [10];
  int         exp_len [10];
  int         exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  svm_dwell_seq #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick),
    .sector_i(sector), .subtri_i(subtri),
    .dwell0_i(d0), .dwell1_i(d1), .dwell2_i(d2),
    .phase_a_o(pa), .phase_b_o(pb), .phase_c_o(pc), .active_o(active)
  );

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4 list: {a,b,c} 2-bit codes, sel, pair
  function automatic logic [8:0] ref_entry(int sub, int i);
    case (sub)
      0: case (i) 0: return {6'b00_11_11, 2'd0, 1'b1}; 1: return {6'b00_00_11, 2'd1, 1'b1};
                  2: return {6'b00_00_00, 2'd2, 1'b0}; 3: return {6'b01_00_00, 2'd0, 1'b1};
                  default: return {6'b01_01_00, 2'd1, 1'b1}; endcase
      1: case (i) 0: return {6'b00_11_11, 2'd0, 1'b1}; 1: return {6'b01_11_11, 2'd2, 1'b0};
                  2: return {6'b01_00_11, 2'd1, 1'b0}; default: return {6'b01_00_00, 2'd0, 1'b1}; endcase
      2: case (i) 0: return {6'b00_11_11, 2'd0, 1'b1}; 1: return {6'b00_00_11, 2'd1, 1'b1};
                  2: return {6'b01_00_11, 2'd2, 1'b0}; 3: return {6'b01_00_00, 2'd0, 1'b1};
                  default: return {6'b01_01_00, 2'd1, 1'b1}; endcase
      default: case (i) 0: return {6'b00_00_11, 2'd0, 1'b1}; 1: return {6'b01_00_11, 2'd1, 1'b0};
                  2: return {6'b01_01_11, 2'd2, 1'b0}; default: return {6'b01_01_00, 2'd0, 1'b1}; endcase
    endcase
  endfunction

  function automatic logic [1:0] ng(logic [1:0] x);
    return (x == 2'b01) ? 2'b11 : (x == 2'b11) ? 2'b01 : 2'b00;
  endfunction

  // R3 rotation, R5 lengths, R6 order, R8 skip
  task automatic build_exp(int sec, int sub, int a0, int a1, int a2);
    int L = (sub % 2 == 1) ? 4 : 5;
    exp_n = 0;
    for (int p = 0; p < 2 * L; p++) begin
      int e = (p < L) ? p : 2 * L - 1 - p;
      logic [8:0] r = ref_entry(sub, e);
      logic [5:0] s = r[8:3];
      int dv = (r[2:1] == 0) ? a0 : (r[2:1] == 1) ? a1 : a2;
      int sg = r[0] ? dv / 4 : dv / 2;
      for (int k = 0; k < sec; k++) s = {ng(s[3:2]), ng(s[1:0]), ng(s[5:4])};
      if (sg != 0) begin
        exp_st[exp_n] = s;
        exp_len[exp_n] = sg;
        exp_n++;
      end
    end
  endtask

  task automatic do_start(int sec, int sub, int a0, int a1, int a2, logic tk);
    @(negedge clk);
    sector = 3'(sec); subtri = 2'(sub);
    d0 = DW'(a0); d1 = DW'(a1); d2 = DW'(a2);
    start = 1'b1; tick = tk;
    @(negedge clk);
    start = 1'b0; tick = 1'b0;
  endtask

  // walk the expected list; stop early after limit ticks if limit >= 0
  task automatic play(string req, int limit, bit adj);
    int ticks = 0;
    logic [5:0] prev = {pa, pb, pc};
    for (int j = 0; j < exp_n; j++) begin
      check(req, {active, pa, pb, pc}, {1'b1, exp_st[j]});
      if (adj && j > 0)
        check("R9", 7'($countones({pa != prev[5:4], pb != prev[3:2], pc != prev[1:0]}) <= 1), 7'd1);
      prev = {pa, pb, pc};
      for (int k = 0; k < exp_len[j]; k++) begin
        if (limit >= 0 && ticks == limit) begin
          tick = 1'b0;
          return;
        end
        tick = 1'b1;
        @(negedge clk);
        ticks++;
      end
    end
    tick = 1'b0;
    check({req, " R7 end"}, {active, pa, pb, pc}, {1'b0, exp_st[exp_n-1]});
  endtask

  task automatic t_reset();
    check("R1 reset", {active, pa, pb, pc}, 7'd0);
  endtask

  task automatic t_basic();
    build_exp(0, 0, 40, 20, 10);
    do_start(0, 0, 40, 20, 10, 1'b0);
    play("R4 R5 R6", -1, 1'b1);
  endtask

  task automatic t_sectors();
    build_exp(2, 1, 24, 16, 12); do_start(2, 1, 24, 16, 12, 1'b0); play("R3 s2", -1, 1'b1);
    build_exp(5, 2, 32, 8, 20);  do_start(5, 2, 32, 8, 20, 1'b0);  play("R3 s5", -1, 1'b1);
    build_exp(3, 3, 16, 30, 18); do_start(3, 3, 16, 30, 18, 1'b0); play("R3 s3", -1, 1'b1);
    build_exp(7, 0, 20, 12, 8);  do_start(7, 0, 20, 12, 8, 1'b0);  play("R3 alias", -1, 1'b0);
  endtask

  task automatic t_zero_skip();
    build_exp(0, 0, 3, 20, 0);
    do_start(0, 0, 3, 20, 0, 1'b0);
    play("R8", -1, 1'b0);
  endtask

  task automatic t_restart();
    build_exp(1, 1, 40, 40, 40);
    do_start(1, 1, 40, 40, 40, 1'b0);
    play("R10 first", 7, 1'b0);
    build_exp(4, 3, 12, 10, 6);
    do_start(4, 3, 12, 10, 6, 1'b1);
    play("R10 restart", -1, 1'b0);
  endtask

  task automatic t_freeze();
    build_exp(0, 2, 20, 20, 20);
    do_start(0, 2, 20, 20, 20, 1'b0);
    sector = 3'd5; subtri = 2'd3; d0 = 8'd200; d1 = 8'd1; d2 = 8'd99;
    play("R2", -1, 1'b0);
  endtask

  task automatic t_hold();
    logic [5:0] snap;
    build_exp(2, 0, 16, 16, 16);
    do_start(2, 0, 16, 16, 16, 1'b0);
    play("R12 run", 3, 1'b0);
    snap = {pa, pb, pc};
    repeat (6) @(negedge clk);
    check("R12 hold", {active, pa, pb, pc}, {1'b1, snap});
  endtask

  task automatic t_all_zero();
    logic [5:0] snap;
    build_exp(0, 1, 8, 8, 8);
    do_start(0, 1, 8, 8, 8, 1'b0);
    play("R11 pre", -1, 1'b0);
    snap = {pa, pb, pc};
    do_start(3, 1, 1, 1, 1, 1'b0);
    check("R11 zero start", {active, pa, pb, pc}, {1'b0, snap});
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    check("R11 idle ticks", {active, pa, pb, pc}, {1'b0, snap});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sectors();
    t_zero_skip();
    t_restart();
    t_freeze();
    t_hold();
    t_all_zero();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule